// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This peripheral supervises software by counting down a 12-bit value. It counts on a tick that is derived from a slow-clock enable strobe divided by a parameterised prescaler, 128 by default. Software programs the configuration word once after reset: the reload value, the restart window, and the reset behaviour. After that it must keep servicing the watchdog by writing a keyed restart word. If the countdown runs out, a sticky flag is set. Depending on the configuration, either a system-wide or a processor-only reset strobe is also emitted.

A restart is legal only while the count has already fallen to or below the programmed window limit. A restart issued too early is flagged as an error, and it can also fire the reset. A disable bit in the configuration word silences the block completely. A debug-halt qualifier lets an external halt signal freeze the countdown. Once the configuration word has been written, nothing can stop or reprogram the timer short of a hardware reset.

Register access is a single-cycle strobe interface with a 2-bit select. Select 0 is the keyed restart port (write-only). Select 1 is the configuration word. Select 2 is status, and reading it clears the sticky flags.

Top module: `wdt_lockwin`

## Requirements
- R1: Each prescaler tick is produced by 128 qualified `slow_en_i` strobes (parameter PRESCALE). Each tick lowers the count by one. After a load of value V, the underflow occurs on tick V+1, so that load to reset strobe takes (V+1)*PRESCALE qualified strobes.
- R2: The configuration word has these fields: value [11:0], reset-enable [12], processor-only [13], disable [14], debug-freeze [15], window limit [27:16], and lock flag [31] (read-only). The first write after reset takes effect, sets the lock flag, loads the count with the new value and clears the prescaler. Every later write is ignored.
- R3: A write to select 0 restarts the timer only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other key, or bit 0 clear, changes nothing.
- R4: A keyed restart is accepted only when the current count is at or below the window limit. An accepted restart reloads the count and clears the prescaler. A restart outside the window leaves the count unchanged and sets the error flag (status bit 1).
- R5: Underflow sets the underflow flag (status bit 0). The count then stays at 0 and no further underflow occurs until a restart is accepted.
- R6: A reset strobe lasts 4 cycles (parameter PULSE_LEN). It starts on an underflow or an out-of-window restart, but only when reset-enable is 1. It appears on `sys_rst_o` when processor-only is 0 and on `cpu_rst_o` when processor-only is 1. The two outputs are never high together.
- R7: With disable set, the count never changes, restarts are ignored, and neither reset output is raised.
- R8: With debug-freeze set, the count and prescaler hold while `dbg_halt_i` is 1. With debug-freeze clear, `dbg_halt_i` has no effect.
- R9: Reading status (select 2) returns the count in bits [27:16], the error flag in bit 1 and the underflow flag in bit 0. It clears both flags on the clock edge, but a flag being set in that same cycle stays set.
- R10: When an accepted restart falls in the same cycle as the tick that would underflow, the restart wins. The count reloads and no flag or reset strobe results.
- R11: After reset, the configuration word reads 0x0FFF9FFF (value and window 0xFFF, reset-enable and debug-freeze set, unlocked). The status word reads 0x0FFF0000, and both reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_en_i | input | 1 | One strobe per slow-clock period, synchronous to clk_i |
| dbg_halt_i | input | 1 | Debugger halt indication |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status on select 2) |
| addr_i | input | 2 | Register select: 0 restart, 1 configuration, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| sys_rst_o | output | 1 | System-wide reset strobe |
| cpu_rst_o | output | 1 | Processor-only reset strobe |

## Verification
The delicate overlap is a keyed restart landing on exactly the edge where the prescaler wraps while the count sits at zero. Both the reload and the underflow then claim the same clock. The bench tracks the prescaler phase in its own model and issues the restart so that it lands on that edge. It then judges the outcome from the status word and the reset outputs: the count must be reloaded, the underflow flag must be clear, and no strobe may appear. An early restart that raises the error flag and the reset strobe in one step is checked the same way, against the window limit.

// File: rtl/wdt_lockwin_pkg.sv
package wdt_lockwin_pkg;
  parameter int unsigned CNT_W  = 12;
  parameter int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  localparam int unsigned F_RSTEN = CNT_W;
  localparam int unsigned F_PROC  = CNT_W + 1;
  localparam int unsigned F_DIS   = CNT_W + 2;
  localparam int unsigned F_DBG   = CNT_W + 3;
  localparam int unsigned F_DELTA = CNT_W + 4;
  localparam int unsigned F_LOCK  = DATA_W - 1;
  localparam int unsigned S_CNT   = 16;
  localparam int unsigned KEY_W   = 8;

  typedef struct packed {
    logic             dbg;
    logic             dis;
    logic             proc;
    logic             rst_en;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] value;
  } mode_t;

  localparam mode_t MODE_RST = '{dbg: 1'b1, dis: 1'b0, proc: 1'b0, rst_en: 1'b1,
                                 delta: {CNT_W{1'b1}}, value: {CNT_W{1'b1}}};
endpackage

// File: rtl/wdt_lockwin_presc.sv
module wdt_lockwin_presc #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic slow_en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          step;

  assign step   = run_i & slow_en_i;
  assign tick_o = step & (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else if (step)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_lockwin_cnt.sv
module wdt_lockwin_cnt
  import wdt_lockwin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] delta_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o,
  output logic             uflow_o,
  output logic             win_err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             in_win;

  assign in_win    = (cnt_q <= delta_i);
  assign reload_o  = (restart_i & in_win) | load_i;
  assign win_err_o = restart_i & ~in_win;
  // restart on the same edge as the final tick takes priority
  assign uflow_o   = tick_i & (cnt_q == '0) & ~expired_q & ~reload_o;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= {CNT_W{1'b1}};
      expired_q <= 1'b0;
    end else if (reload_o) begin
      cnt_q     <= load_val_i;
      expired_q <= 1'b0;
    end else begin
      if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (uflow_o)               expired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_lockwin_cfg.sv
module wdt_lockwin_cfg
  import wdt_lockwin_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_wr_i,
  input  mode_t mode_new_i,
  input  logic  stat_rd_i,
  input  logic  uflow_i,
  input  logic  win_err_i,
  output mode_t mode_o,
  output logic  lock_o,
  output logic  mode_load_o,
  output logic  uf_flag_o,
  output logic  err_flag_o
);
  mode_t mode_q;
  logic  lock_q, uf_q, err_q;

  assign mode_load_o = mode_wr_i & ~lock_q;
  assign mode_o      = mode_q;
  assign lock_o      = lock_q;
  assign uf_flag_o   = uf_q;
  assign err_flag_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      lock_q <= 1'b0;
    end else if (mode_load_o) begin
      mode_q <= mode_new_i;
      lock_q <= 1'b1;
    end
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (uflow_i)        uf_q <= 1'b1;
      else if (stat_rd_i) uf_q <= 1'b0;
      if (win_err_i)      err_q <= 1'b1;
      else if (stat_rd_i) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_lockwin_pulse.sv
module wdt_lockwin_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic cpu_sel_i,
  input  logic quiet_i,
  output logic sys_rst_o,
  output logic cpu_rst_o
);
  localparam int unsigned LW = $clog2(PULSE_LEN + 1);
  localparam logic [LW-1:0] LEN = LW'(PULSE_LEN);

  logic [LW-1:0] left_q;
  logic          sel_q;
  logic          active;

  assign active    = (left_q != '0) & ~quiet_i;
  assign sys_rst_o = active & ~sel_q;
  assign cpu_rst_o = active & sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sel_q  <= 1'b0;
    end else if (trig_i) begin
      left_q <= LEN;
      sel_q  <= cpu_sel_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_lockwin.sv
module wdt_lockwin
  import wdt_lockwin_pkg::*;
#(
  parameter int unsigned PRESCALE  = 128,
  parameter int unsigned PULSE_LEN = 4,
  parameter logic [KEY_W-1:0] KEY  = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              dbg_halt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_o,
  output logic              cpu_rst_o
);
  mode_t            mode_q, mode_new;
  logic             lock_q, mode_load, mode_wr, stat_rd;
  logic             restart, tick, reload, uflow, win_err;
  logic             uf_flag, err_flag, halt_act, run, trig;
  logic [CNT_W-1:0] cnt, load_val;

  assign mode_new.value  = wdata_i[CNT_W-1:0];
  assign mode_new.rst_en = wdata_i[F_RSTEN];
  assign mode_new.proc   = wdata_i[F_PROC];
  assign mode_new.dis    = wdata_i[F_DIS];
  assign mode_new.dbg    = wdata_i[F_DBG];
  assign mode_new.delta  = wdata_i[F_DELTA +: CNT_W];

  assign mode_wr  = wr_en_i & (addr_i == REG_MODE);
  assign stat_rd  = rd_en_i & (addr_i == REG_STAT);
  assign restart  = wr_en_i & (addr_i == REG_CTRL) & (wdata_i[DATA_W-1 -: KEY_W] == KEY)
                    & wdata_i[0] & ~mode_q.dis;
  assign halt_act = mode_q.dbg & dbg_halt_i;
  assign run      = ~mode_q.dis & ~halt_act;
  assign load_val = mode_load ? mode_new.value : mode_q.value;
  assign trig     = mode_q.rst_en & (uflow | win_err);

  wdt_lockwin_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr),
    .mode_new_i (mode_new),
    .stat_rd_i  (stat_rd),
    .uflow_i    (uflow),
    .win_err_i  (win_err),
    .mode_o     (mode_q),
    .lock_o     (lock_q),
    .mode_load_o(mode_load),
    .uf_flag_o  (uf_flag),
    .err_flag_o (err_flag)
  );

  wdt_lockwin_presc #(.DIV(PRESCALE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (reload),
    .run_i    (run),
    .slow_en_i(slow_en_i),
    .tick_o   (tick)
  );

  wdt_lockwin_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (restart),
    .load_i    (mode_load),
    .load_val_i(load_val),
    .delta_i   (mode_q.delta),
    .cnt_o     (cnt),
    .reload_o  (reload),
    .uflow_o   (uflow),
    .win_err_o (win_err)
  );

  wdt_lockwin_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .cpu_sel_i(mode_q.proc),
    .quiet_i  (mode_q.dis),
    .sys_rst_o(sys_rst_o),
    .cpu_rst_o(cpu_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_MODE: begin
        rdata_o[CNT_W-1:0]        = mode_q.value;
        rdata_o[F_RSTEN]          = mode_q.rst_en;
        rdata_o[F_PROC]           = mode_q.proc;
        rdata_o[F_DIS]            = mode_q.dis;
        rdata_o[F_DBG]            = mode_q.dbg;
        rdata_o[F_DELTA +: CNT_W] = mode_q.delta;
        rdata_o[F_LOCK]           = lock_q;
      end
      REG_STAT: begin
        rdata_o[S_CNT +: CNT_W] = cnt;
        rdata_o[1]              = err_flag;
        rdata_o[0]              = uf_flag;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_lockwin_chk.sv
module wdt_lockwin_chk
  import wdt_lockwin_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             reload_i,
  input logic             halt_i,
  input logic             lock_i,
  input mode_t            mode_i,
  input logic             sys_rst_i,
  input logic             cpu_rst_i
);
  AST_RST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_rst_i && cpu_rst_i)); // R6

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (lock_i && $stable(mode_i))); // R2

  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i.dis |-> (!sys_rst_i && !cpu_rst_i)); // R7

  AST_CNT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> (cnt_i <= $past(cnt_i))); // R1

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(cnt_i)); // R8

  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !reload_i) |=> (cnt_i == '0)); // R5

  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i || cpu_rst_i) |=> (sys_rst_i || cpu_rst_i || mode_i.dis)); // R6
endmodule

bind wdt_lockwin wdt_lockwin_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt),
  .reload_i (reload),
  .halt_i   (halt_act),
  .lock_i   (lock_q),
  .mode_i   (mode_q),
  .sys_rst_i(sys_rst_o),
  .cpu_rst_i(cpu_rst_o)
);

// File: tb/wdt_lockwin_tb_top.sv
module wdt_lockwin_tb_top;
  localparam int PRE = 128;
  localparam int PL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b1, halt = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst, cpu_rst;

  int checks = 0, fails = 0;
  string cur_req = "R11";
  int sys_hi = 0, cpu_hi = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_pre, m_value, m_delta, m_pulse;
  bit m_exp, m_uf, m_err, m_psel, m_lock, m_rsten, m_proc, m_dis, m_dbg;

  always #10 clk = ~clk;

  wdt_lockwin dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .dbg_halt_i(halt),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
  );

  function automatic logic [31:0] mk_mode(int v, int d, bit re, bit pr, bit di, bit db);
    logic [31:0] w;
    w = '0;
    w[11:0]  = v[11:0];
    w[12]    = re;
    w[13]    = pr;
    w[14]    = di;
    w[15]    = db;
    w[27:16] = d[11:0];
    return w;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [1:0] a);
    logic [31:0] w;
    w = '0;
    if (a == 2'd1) begin
      w = mk_mode(m_value, m_delta, m_rsten, m_proc, m_dis, m_dbg);
      w[31] = m_lock;
    end else if (a == 2'd2) begin
      w[27:16] = m_cnt[11:0];
      w[1] = m_err;
      w[0] = m_uf;
    end
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit run, tick, mwr, rreq, ok, bad, rel, uf, trig, rdc;
    if (!rst_n) begin
      m_cnt = 4095; m_pre = 0; m_exp = 0; m_uf = 0; m_err = 0;
      m_pulse = 0; m_psel = 0; m_lock = 0;
      m_value = 4095; m_delta = 4095; m_rsten = 1; m_proc = 0; m_dis = 0; m_dbg = 1;
    end else begin
      run  = !m_dis && !(m_dbg && halt);
      tick = run && slow_en && (m_pre == PRE - 1);
      mwr  = wr_en && addr == 2'd1 && !m_lock;
      rreq = wr_en && addr == 2'd0 && wdata[31:24] == 8'hA5 && wdata[0] && !m_dis;
      ok   = rreq && (m_cnt <= m_delta);
      bad  = rreq && !ok;
      rel  = ok || mwr;
      uf   = tick && m_cnt == 0 && !m_exp && !rel;
      trig = m_rsten && (uf || bad);
      rdc  = rd_en && addr == 2'd2;
      if (rel) m_pre = 0;
      else if (run && slow_en) m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
      if (rel) begin
        m_cnt = mwr ? int'(wdata[11:0]) : m_value;
        m_exp = 0;
      end else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
      if (uf) m_exp = 1;
      if (uf) m_uf = 1; else if (rdc) m_uf = 0;
      if (bad) m_err = 1; else if (rdc) m_err = 0;
      if (trig) begin m_pulse = PL; m_psel = m_proc; end
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (mwr) begin
        m_lock = 1; m_value = int'(wdata[11:0]); m_delta = int'(wdata[27:16]);
        m_rsten = wdata[12]; m_proc = wdata[13]; m_dis = wdata[14]; m_dbg = wdata[15];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, rdata, exp_rdata(addr), "model rdata");
      check(cur_req, {31'd0, sys_rst}, {31'd0, (m_pulse > 0 && !m_psel && !m_dis)}, "model sys_rst");
      check(cur_req, {31'd0, cpu_rst}, {31'd0, (m_pulse > 0 && m_psel && !m_dis)}, "model cpu_rst");
      if (sys_rst) sys_hi++;
      if (cpu_rst) cpu_hi++;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); #1;
    rd_en = 1'b0; addr = 2'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; halt = 0; slow_en = 1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    logic [31:0] d, d2;
    int s0, n;
    // phase 1: main function
    do_reset();
    cur_req = "R2";
    wr(2'd1, mk_mode(5, 3, 1, 0, 0, 1));
    rd(2'd1, d);
    check("R2", d, mk_mode(5, 3, 1, 0, 0, 1) | 32'h8000_0000, "mode after first write");
    rd(2'd2, d);
    check("R2", d, 32'd5 << 16, "count loaded by mode write");
    wr(2'd1, mk_mode(9, 4095, 0, 1, 1, 0));
    rd(2'd1, d);
    check("R2", d, mk_mode(5, 3, 1, 0, 0, 1) | 32'h8000_0000, "second mode write ignored");

    cur_req = "R4";
    s0 = sys_hi;
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d);
    check("R4", d, (32'd5 << 16) | 32'd2, "early restart flags error, count kept");
    cyc(8);
    check("R6", sys_hi - s0, PL, "sys strobe length on window error");
    check("R6", cpu_hi, 0, "no cpu strobe when processor-only clear");
    cur_req = "R9";
    rd(2'd2, d);
    check("R9", d[1:0], 2'b00, "flags cleared by status read");

    cur_req = "R3";
    while (m_cnt > 3) cyc(1);
    wr(2'd0, 32'h5A00_0001);
    wr(2'd0, 32'hA500_0000);
    rd(2'd2, d);
    check("R3", d, 32'(m_cnt) << 16, "bad key and clear bit ignored");
    check("R3", {31'd0, (m_cnt < 5)}, 32'd1, "count not reloaded by bad restarts");
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d);
    check("R3", d, 32'd5 << 16, "keyed restart in window reloads");

    cur_req = "R8";
    while (m_cnt > 3) cyc(1);
    halt = 1'b1;
    rd(2'd2, d);
    cyc(400);
    rd(2'd2, d2);
    check("R8", d2, d, "count frozen during debug halt");
    halt = 1'b0;

    cur_req = "R1";
    wr(2'd0, 32'hA500_0001);
    for (int i = 0; i < 600; i++) begin slow_en = i[0]; cyc(1); end
    slow_en = 1'b1;

    cur_req = "R10";
    while (!(m_cnt == 0 && m_pre == PRE - 1 && !m_exp)) cyc(1);
    s0 = sys_hi;
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d);
    check("R10", d, 32'd5 << 16, "restart beats underflow tick");
    cyc(6);
    check("R10", sys_hi - s0, 0, "no strobe on collision");

    cur_req = "R5";
    s0 = sys_hi;
    while (!sys_rst) cyc(1);
    rd(2'd2, d);
    check("R5", d[0], 1'b1, "underflow flag set");
    cyc(600);
    rd(2'd2, d);
    check("R5", d, 32'd0, "count held at zero, single event");
    check("R5", sys_hi - s0, PL, "one strobe only after underflow");
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d);
    check("R5", d, 32'd5 << 16, "restart after underflow reloads");

    // phase 2: reset values, processor-only strobe, timing
    cur_req = "R11";
    do_reset();
    rd(2'd1, d);
    check("R11", d, 32'h0FFF_9FFF, "mode reset value");
    rd(2'd2, d);
    check("R11", d, 32'h0FFF_0000, "status reset value");
    check("R11", {30'd0, sys_rst, cpu_rst}, 32'd0, "reset outputs low");
    cur_req = "R1";
    halt = 1'b1;
    s0 = sys_hi;
    n = cpu_hi;
    wr(2'd1, mk_mode(1, 4095, 1, 1, 0, 0));
    begin
      int k = 0;
      while (!cpu_rst && k < 5000) begin cyc(1); k++; end
      check("R1", k, 2 * PRE, "cycles from load to underflow strobe");
      check("R8", k, 2 * PRE, "halt ignored when freeze bit clear");
    end
    halt = 1'b0;
    cyc(8);
    check("R6", cpu_hi - n, PL, "cpu strobe length");
    check("R6", sys_hi - s0, 0, "sys silent when processor-only set");

    // phase 3: reset-enable clear
    cur_req = "R6";
    do_reset();
    s0 = sys_hi; n = cpu_hi;
    wr(2'd1, mk_mode(0, 4095, 0, 0, 0, 1));
    cyc(300);
    rd(2'd2, d);
    check("R6", d[0], 1'b1, "underflow flag without reset-enable");
    check("R6", (sys_hi - s0) + (cpu_hi - n), 0, "no strobe without reset-enable");

    // phase 4: disabled
    cur_req = "R7";
    do_reset();
    s0 = sys_hi; n = cpu_hi;
    wr(2'd1, mk_mode(2, 0, 1, 0, 1, 1));
    cyc(600);
    wr(2'd0, 32'hA500_0001);
    cyc(10);
    rd(2'd2, d);
    check("R7", d, 32'd2 << 16, "disabled: no count, no restart effect");
    check("R7", (sys_hi - s0) + (cpu_hi - n), 0, "disabled: no strobe");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule